// File: doc/BRIEF.md
# Dual-Region SRAM Bank Select Sequence Guard

This block sits between the memory accesses of a data-bus interface and a static RAM that is twice the size the interface needs. The RAM is split into a lower and an upper bank. The interface owns two memory regions: one used while acting as bus controller and one used while acting as remote terminal. Each region has its own bank-select bit. Every access to a region is steered into the bank that region currently selects. The physical address is formed with the bank bit as its most significant bit, then the region index, then the word offset.

A bank change is only safe at the very beginning of a region's initialization sequence. It must happen before any descriptor or data word has landed in the region. The guard marks the start of each sequence, remembers whether the region has been written since then, and raises a sticky sequencing-error flag if the select bit is written too late. The select bit still takes the new value in that case, so the fault stays visible. Choosing the upper bank is a recovery measure. When no memory fault is indicated for the region, selecting the upper bank raises a separate sticky flag.

Top module: `sramBankGuard`

## Requirements
- R1: After reset, both bank-select outputs are 0 (lower bank), both sequencing-error and both bank-rule flags are 0, and neither RAM strobe is active.
- R2: One cycle after an access request, the RAM address equals {bank bit of the addressed region, region index, offset}, where region 0 is the bus-controller region and region 1 is the remote-terminal region. sramWrite is high for a write request and sramRead for a read request. Both strobes are low when no request was made, and they are never high together.
- R3: A select write for a region loads that region's new value into its bank-select output on the next cycle. The other region's bank-select output is not changed.
- R4: A start-of-initialization pulse clears the region's written-since-init state. A memory write to the region sets that state. A memory read does not set it.
- R5: A select write to a region whose written-since-init state is set, with no start-of-initialization pulse in the same cycle, sets that region's sequencing-error flag on the next cycle. The select bit still updates.
- R6: The sequencing-error and bank-rule flags stay set until reset. A start-of-initialization pulse does not clear them.
- R7: A select write of value 1 while that region's memory-fault input is low sets the region's bank-rule flag. A write of value 1 with the fault input high does not set it, and a write of value 0 never sets it.
- R8: A select write and the first memory write to a region may fall in the same cycle. This is legal (no sequencing error), and the access is steered with the bank value held before that cycle. A start pulse and a memory write in the same cycle leave the region marked as written.
- R9: A select write in the same cycle as the region's start-of-initialization pulse is legal, even if the region was written before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initStart | input | NUM_REGIONS | Per-region start-of-initialization pulse |
| selWrite | input | NUM_REGIONS | Per-region bank-select write strobe |
| selValue | input | NUM_REGIONS | Per-region new bank-select value |
| memFault | input | NUM_REGIONS | Per-region memory-fault indication (permits upper bank) |
| accValid | input | 1 | Memory access request |
| accWrite | input | 1 | 1 = write, 0 = read |
| accRegion | input | REGION_W | Region of the access |
| accOffset | input | OFFSET_W | Word offset inside the region |
| sramAddr | output | 1+REGION_W+OFFSET_W | Physical RAM address |
| sramWrite | output | 1 | RAM write strobe |
| sramRead | output | 1 | RAM read strobe |
| bankSel | output | NUM_REGIONS | Current bank-select bits |
| seqErr | output | NUM_REGIONS | Sticky late-select flags |
| faultErr | output | NUM_REGIONS | Sticky upper-bank-without-fault flags |

## Verification
Two functions can fall in the same cycle: a bank-select write and a memory write to the same region. Steering must then use the old bank, and the ordering check must still treat the region as unwritten. The bench provokes this by driving both in one cycle on a freshly initialized region. It judges the result through the scoreboarded RAM address and the absence of a sequencing error, and then confirms that a following select write is flagged. The start-pulse collisions are also provoked and checked at the ports: a start pulse together with a memory write, and a start pulse together with a select write.

// File: rtl/bankGuardPkg.sv
package bankGuardPkg;

  typedef struct packed {
    logic fire;
    logic isWrite;
    logic bank;
  } ctrlStrobes_t;

endpackage

// File: rtl/bankGuardCtrl.sv
module bankGuardCtrl
  import bankGuardPkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int REGION_W = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_REGIONS-1:0] initStart,
  input  logic [NUM_REGIONS-1:0] selWrite,
  input  logic [NUM_REGIONS-1:0] selValue,
  input  logic [NUM_REGIONS-1:0] memFault,
  input  logic                   accValid,
  input  logic                   accWrite,
  input  logic [REGION_W-1:0]    accRegion,
  output logic [NUM_REGIONS-1:0] bankSel,
  output logic [NUM_REGIONS-1:0] seqErr,
  output logic [NUM_REGIONS-1:0] faultErr,
  output ctrlStrobes_t           strobes
);

  logic [NUM_REGIONS-1:0] writtenQ;
  logic [NUM_REGIONS-1:0] hitWrite;
  logic [NUM_REGIONS-1:0] lateSel;
  logic [NUM_REGIONS-1:0] badUpper;

  always_comb begin
    strobes.fire    = accValid;
    strobes.isWrite = accWrite;
    strobes.bank    = bankSel[accRegion];
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    always_comb begin
      hitWrite[i] = accValid && accWrite && (accRegion == REGION_W'(i));
      lateSel[i]  = selWrite[i] && writtenQ[i] && !initStart[i];
      badUpper[i] = selWrite[i] && selValue[i] && !memFault[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankSel[i]  <= 1'b0;
        writtenQ[i] <= 1'b0;
        seqErr[i]   <= 1'b0;
        faultErr[i] <= 1'b0;
      end else begin
        if (selWrite[i]) bankSel[i] <= selValue[i];
        if (hitWrite[i]) writtenQ[i] <= 1'b1;
        else if (initStart[i]) writtenQ[i] <= 1'b0;
        if (lateSel[i]) seqErr[i] <= 1'b1;
        if (badUpper[i]) faultErr[i] <= 1'b1;
      end
    end

    // R3: a select write lands in the select output next cycle
    p_sel_loads_r3: assert property (@(posedge clk) disable iff (!rstN)
      selWrite[i] |=> bankSel[i] == $past(selValue[i]));
    // R3: without a select write the bit holds
    p_sel_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
      !selWrite[i] |=> $stable(bankSel[i]));
    // R6: both error flags are sticky
    p_seq_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      seqErr[i] |=> seqErr[i]);
    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      faultErr[i] |=> faultErr[i]);
    // R5: a write to the region followed by a select write without a start pulse is flagged
    p_late_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
      hitWrite[i] ##1 (selWrite[i] && !initStart[i]) |=> seqErr[i]);
    // R9: a select write alongside a start pulse never raises a new error
    p_init_sel_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
      (selWrite[i] && initStart[i] && !seqErr[i]) |=> !seqErr[i]);
  end

endmodule

// File: rtl/bankGuardPath.sv
module bankGuardPath
  import bankGuardPkg::*;
#(
  parameter int REGION_W = 1,
  parameter int OFFSET_W = 10,
  localparam int ADDR_W = 1 + REGION_W + OFFSET_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [REGION_W-1:0] accRegion,
  input  logic [OFFSET_W-1:0] accOffset,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic                sramWrite,
  output logic                sramRead
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramAddr  <= '0;
      sramWrite <= 1'b0;
      sramRead  <= 1'b0;
    end else begin
      sramWrite <= strobes.fire && strobes.isWrite;
      sramRead  <= strobes.fire && !strobes.isWrite;
      if (strobes.fire) sramAddr <= {strobes.bank, accRegion, accOffset};
    end
  end

  // R2: read and write strobes never together
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sramWrite, sramRead}));
  // R2: no request, no strobe next cycle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fire |=> !sramWrite && !sramRead);

endmodule

// File: rtl/sramBankGuard.sv
module sramBankGuard
  import bankGuardPkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int OFFSET_W = 10,
  localparam int REGION_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int ADDR_W = 1 + REGION_W + OFFSET_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_REGIONS-1:0] initStart,
  input  logic [NUM_REGIONS-1:0] selWrite,
  input  logic [NUM_REGIONS-1:0] selValue,
  input  logic [NUM_REGIONS-1:0] memFault,
  input  logic                   accValid,
  input  logic                   accWrite,
  input  logic [REGION_W-1:0]    accRegion,
  input  logic [OFFSET_W-1:0]    accOffset,
  output logic [ADDR_W-1:0]      sramAddr,
  output logic                   sramWrite,
  output logic                   sramRead,
  output logic [NUM_REGIONS-1:0] bankSel,
  output logic [NUM_REGIONS-1:0] seqErr,
  output logic [NUM_REGIONS-1:0] faultErr
);

  ctrlStrobes_t strobes;

  bankGuardCtrl #(.NUM_REGIONS(NUM_REGIONS), .REGION_W(REGION_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .initStart(initStart), .selWrite(selWrite),
    .selValue(selValue), .memFault(memFault), .accValid(accValid),
    .accWrite(accWrite), .accRegion(accRegion), .bankSel(bankSel),
    .seqErr(seqErr), .faultErr(faultErr), .strobes(strobes)
  );

  bankGuardPath #(.REGION_W(REGION_W), .OFFSET_W(OFFSET_W)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accRegion(accRegion),
    .accOffset(accOffset), .sramAddr(sramAddr), .sramWrite(sramWrite),
    .sramRead(sramRead)
  );

endmodule

// File: tb/sramBankGuard_tb.sv
module sramBankGuard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 10;
  localparam int A_W = 2 + OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] initStart = '0, selWrite = '0, selValue = '0, memFault = '0;
  logic accValid = 1'b0, accWrite = 1'b0, accRegion = 1'b0;
  logic [OFF_W-1:0] accOffset = '0;
  logic [A_W-1:0] sramAddr;
  logic sramWrite, sramRead;
  logic [1:0] bankSel, seqErr, faultErr;

  int total = 0;
  int bad = 0;
  logic [A_W+1:0] expQ[$];
  logic [1:0] mSel = '0, mWr = '0, mSeq = '0, mFlt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sramBankGuard #(.NUM_REGIONS(2), .OFFSET_W(OFF_W)) u_dut (
    .clk(clk), .rstN(rstN), .initStart(initStart), .selWrite(selWrite),
    .selValue(selValue), .memFault(memFault), .accValid(accValid),
    .accWrite(accWrite), .accRegion(accRegion), .accOffset(accOffset),
    .sramAddr(sramAddr), .sramWrite(sramWrite), .sramRead(sramRead),
    .bankSel(bankSel), .seqErr(seqErr), .faultErr(faultErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, with the model updated from the requirements
  task automatic drive(input logic [1:0] iS, input logic [1:0] sW, input logic [1:0] sV,
                       input logic [1:0] flt, input logic aV, input logic aW,
                       input logic aR, input logic [OFF_W-1:0] aO);
    @(negedge clk);
    initStart = iS; selWrite = sW; selValue = sV; memFault = flt;
    accValid = aV; accWrite = aW; accRegion = aR; accOffset = aO;
    if (aV) expQ.push_back({aW, !aW, mSel[aR], aR, aO});
    for (int r = 0; r < 2; r++) begin
      if (sW[r] && mWr[r] && !iS[r]) mSeq[r] = 1'b1;
      if (sW[r] && sV[r] && !flt[r]) mFlt[r] = 1'b1;
      if (sW[r]) mSel[r] = sV[r];
      if (aV && aW && (aR == r[0])) mWr[r] = 1'b1;
      else if (iS[r]) mWr[r] = 1'b0;
    end
    @(negedge clk);
    initStart = '0; selWrite = '0; selValue = '0;
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  task automatic chkStatus(input string tag);
    chk({tag, " bankSel"}, int'(bankSel), int'(mSel));
    chk({tag, " seqErr"}, int'(seqErr), int'(mSeq));
    chk({tag, " faultErr"}, int'(faultErr), int'(mFlt));
  endtask

  // monitor: compare each RAM access with the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && (sramWrite || sramRead)) begin
        if (expQ.size() == 0) chk("R2 unexpected access", int'({sramWrite, sramRead, sramAddr}), 0);
        else begin
          logic [A_W+1:0] e;
          e = expQ.pop_front();
          chk("R2 access", int'({sramWrite, sramRead, sramAddr}), int'(e));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bankSel", int'(bankSel), 0);
    chk("R1 seqErr", int'(seqErr), 0);
    chk("R1 faultErr", int'(faultErr), 0);
    chk("R1 strobes", int'({sramWrite, sramRead}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 plain steering, lower bank, both regions
    drive(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 10'h005);
    drive(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 10'h3ff);
    // R3 R7 BC to upper with fault: legal, RT untouched; mWr[0] set so init first
    drive(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, '0);
    drive(2'b00, 2'b01, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, '0);
    chkStatus("R3 R7 upper with fault");
    // R2 write now goes to bank 1
    drive(2'b00, 2'b00, 2'b00, 2'b01, 1'b1, 1'b1, 1'b0, 10'h03a);
    // R9 start pulse together with select write: legal though written
    drive(2'b01, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, '0);
    chkStatus("R9 init with select");
    // R8 start pulse and write in same cycle leave region written
    drive(2'b01, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 10'h011);
    // R5 late select: flagged, bit still updates
    drive(2'b00, 2'b01, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, '0);
    chkStatus("R5 late select");
    // R6 start pulse does not clear flag
    drive(2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, '0);
    chkStatus("R6 sticky after init");
    // R4 reads do not mark region written
    drive(2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, '0);
    drive(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 10'h020);
    drive(2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, '0);
    chkStatus("R4 read only");
    // R7 upper without fault flagged; value 0 afterwards keeps flag (R6)
    drive(2'b00, 2'b10, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, '0);
    chkStatus("R7 upper no fault");
    drive(2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, '0);
    chkStatus("R6 R7 value zero");
    // R8 select and first write same cycle: legal, old bank used
    drive(2'b10, 2'b00, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, '0);
    drive(2'b00, 2'b10, 2'b10, 2'b10, 1'b1, 1'b1, 1'b1, 10'h007);
    chkStatus("R8 same cycle");
    drive(2'b00, 2'b00, 2'b00, 2'b10, 1'b1, 1'b0, 1'b1, 10'h007);
    drive(2'b00, 2'b10, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, '0);
    chkStatus("R8 next select flagged");
    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule